// File: doc/BRIEF.md
# Lane-Split Scalar Shifter

This block performs a logical shift on a 24-bit word that can be divided, while running, into independent lanes. The word is built from three 8-bit segments. A 2-bit split vector decides whether the two internal seams (at bit 8 and bit 16) are open or closed. Neighbouring segments joined by an open seam form one wider lane. Every lane is shifted by the same scalar amount, and a direction input picks left or right.

Each lane first reduces the shared amount to the number of low bits its own width needs. It then shifts on its own terms. Bits pushed past a lane edge are lost and never enter the lane next to it. Positions that the shift vacates take zeros. The block has no clock. Its result follows its inputs directly, so it can sit inside any execution stage that needs SIMD-style shifts of 8-, 16- or 24-bit elements.

There is no sequencing inside the block, so it has no states and no transitions. Its only "mode" is the split setting, which is decoded combinationally on every evaluation.

Top module: `pss_shifter`

## Requirements
- R1: With split_i = 2'b00 the 24 bits form one lane, and the shift amount used is amount_i[4:0].
- R2: With split_i = 2'b01 the lanes are bits [7:0] (shifted by amount_i[2:0]) and bits [23:8] (shifted by amount_i[3:0]).
- R3: With split_i = 2'b10 the lanes are bits [15:0] (shifted by amount_i[3:0]) and bits [23:16] (shifted by amount_i[2:0]).
- R4: With split_i = 2'b11 there are three 8-bit lanes, [7:0], [15:8] and [23:16], each shifted by amount_i[2:0].
- R5: dir_right_i = 0 selects a logical left shift (toward bit 23), and dir_right_i = 1 selects a logical right shift (toward bit 0).
- R6: Every bit position that a shift vacates inside a lane reads 0, and an all-zero data word always gives an all-zero result.
- R7: No bit moves across a seam whose split bit is 1. split_i[0] governs the seam between bits 7 and 8, and split_i[1] the seam between bits 15 and 16.
- R8: When a lane's reduced amount is not smaller than the lane width (24 to 31 in the single 24-bit lane), that lane's result is all zeros.
- R9: The result is a pure function of the present inputs, with no clock and no stored state.
- R10: amount_i bits above those a lane uses have no effect on that lane. For example, an amount of 9 shifts an 8-bit lane by 1, and an amount whose low three bits are zero leaves all three 8-bit lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 24 | Word to be shifted |
| amount_i | input | 5 | Shared scalar shift amount |
| dir_right_i | input | 1 | 0 = shift left, 1 = shift right |
| split_i | input | 2 | Seam controls: bit 0 for the seam at 8, bit 1 for the seam at 16; 1 splits |
| result_o | output | 24 | Shifted word |

## Verification
Every result is due in the same evaluation as its stimulus, with zero cycles of latency. The bench applies a new input set just after a rising edge of its own sampling clock and compares on the following falling edge, after the combinational logic has settled. A behavioural per-lane model supplies the expected word. The bench sweeps every split setting, both directions, every amount from 0 to 31 and several data patterns, then adds directed cases for seam leakage, zero fill and masked amounts.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int DATA_W = 24;
    localparam int SEG_W  = 8;
    localparam int SEGS   = DATA_W / SEG_W;
    localparam int GATE_W = SEGS - 1;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef logic [IDX_W-1:0] bit_idx_t;
    typedef logic [AMT_W-1:0] amt_t;
endpackage

// File: rtl/pss_lane_map.sv
module pss_lane_map
    import pss_pkg::*;
(
    input  logic [GATE_W-1:0]          split_i,
    output logic [SEGS-1:0][IDX_W-1:0] lo_bit_o,
    output logic [SEGS-1:0][IDX_W-1:0] hi_bit_o,
    output logic [SEGS-1:0][AMT_W-1:0] amt_mask_o
);
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        always_comb begin
            int lo_seg;
            int hi_seg;
            int width;
            logic stop;
            lo_seg = k;
            stop   = 1'b0;
            for (int j = k; j > 0; j--) begin
                if (!stop && !split_i[j-1]) lo_seg = j - 1;
                else stop = 1'b1;
            end
            hi_seg = k;
            stop   = 1'b0;
            for (int j = k; j < SEGS - 1; j++) begin
                if (!stop && !split_i[j]) hi_seg = j + 1;
                else stop = 1'b1;
            end
            width = (hi_seg - lo_seg + 1) * SEG_W;
            amt_mask_o[k] = '0;
            for (int b = 0; b < AMT_W; b++) begin
                if ((1 << b) < width) amt_mask_o[k][b] = 1'b1;
            end
            lo_bit_o[k] = IDX_W'(lo_seg * SEG_W);
            hi_bit_o[k] = IDX_W'((hi_seg + 1) * SEG_W - 1);
        end
    end
endmodule

// File: rtl/pss_bit_sel.sv
module pss_bit_sel
    import pss_pkg::*;
#(
    parameter int POS = 0
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              dir_right_i,
    input  logic [IDX_W-1:0]  lo_bit_i,
    input  logic [IDX_W-1:0]  hi_bit_i,
    output logic              bit_o
);
    always_comb begin
        int s;
        int src;
        s     = int'(amt_i);
        bit_o = 1'b0;
        if (!dir_right_i) begin
            src = POS - s;
            if (src >= int'(lo_bit_i)) bit_o = data_i[src[IDX_W-1:0]];
        end else begin
            src = POS + s;
            if (src <= int'(hi_bit_i)) bit_o = data_i[src[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/pss_shifter.sv
module pss_shifter
    import pss_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              dir_right_i,
    input  logic [GATE_W-1:0] split_i,
    output logic [DATA_W-1:0] result_o
);
    logic [SEGS-1:0][IDX_W-1:0] lo_bit;
    logic [SEGS-1:0][IDX_W-1:0] hi_bit;
    logic [SEGS-1:0][AMT_W-1:0] amt_mask;
    logic [SEGS-1:0][AMT_W-1:0] seg_amt;

    pss_lane_map u_map (
        .split_i    (split_i),
        .lo_bit_o   (lo_bit),
        .hi_bit_o   (hi_bit),
        .amt_mask_o (amt_mask)
    );

    for (genvar k = 0; k < SEGS; k++) begin : g_amt
        assign seg_amt[k] = amount_i & amt_mask[k];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int SEG = i / SEG_W;
        pss_bit_sel #(.POS(i)) u_sel (
            .data_i      (data_i),
            .amt_i       (seg_amt[SEG]),
            .dir_right_i (dir_right_i),
            .lo_bit_i    (lo_bit[SEG]),
            .hi_bit_i    (hi_bit[SEG]),
            .bit_o       (result_o[i])
        );
    end
endmodule

// File: rtl/pss_shifter_chk.sv
module pss_shifter_chk
    import pss_pkg::*;
(
    input logic [DATA_W-1:0] data_i,
    input logic [AMT_W-1:0]  amount_i,
    input logic              dir_right_i,
    input logic [GATE_W-1:0] split_i,
    input logic [DATA_W-1:0] result_o
);
    always_comb begin
        p_zero_data_r6: assert (data_i != '0 || result_o == '0)
            else $error("zero data gave nonzero result");
        p_masked_identity_r10: assert (!(split_i == 2'b11 && amount_i[2:0] == 3'd0)
                                       || result_o == data_i)
            else $error("upper amount bits changed 8-bit lanes");
        p_full_clear_r8: assert (!(split_i == 2'b00 && amount_i >= 5'd24) || result_o == '0)
            else $error("oversized shift left bits in 24-bit lane");
        p_left_fill_r6: assert (!(split_i == 2'b11 && !dir_right_i && amount_i[2:0] != 3'd0)
                                || (!result_o[0] && !result_o[8] && !result_o[16]))
            else $error("left shift did not zero-fill lane bottoms");
        p_no_leak_r7: assert (!(split_i == 2'b11 && dir_right_i && amount_i[2:0] != 3'd0)
                              || (!result_o[7] && !result_o[15] && !result_o[23]))
            else $error("right shift leaked across a closed seam");
    end
endmodule

bind pss_shifter pss_shifter_chk u_chk (
    .data_i      (data_i),
    .amount_i    (amount_i),
    .dir_right_i (dir_right_i),
    .split_i     (split_i),
    .result_o    (result_o)
);

// File: tb/tb_pss_shifter.sv
`timescale 1ns/1ps
module tb_pss_shifter;
    logic        clk = 1'b0;
    logic [23:0] data;
    logic [4:0]  amount;
    logic        dir_right;
    logic [1:0]  split;
    logic [23:0] result;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pss_shifter dut (
        .data_i      (data),
        .amount_i    (amount),
        .dir_right_i (dir_right),
        .split_i     (split),
        .result_o    (result)
    );

    function automatic longint lane_op(longint v, int w, int s, bit right);
        longint m;
        m = (longint'(1) << w) - 1;
        if (s >= w) return 0;
        if (right) return (v & m) >> s;
        return ((v & m) << s) & m;
    endfunction

    function automatic logic [23:0] model(logic [23:0] d, int amt, bit right, logic [1:0] g);
        longint v;
        longint r;
        v = longint'(d);
        case (g)
            2'b00: r = lane_op(v, 24, amt % 32, right);
            2'b01: r = lane_op(v & 'hFF, 8, amt % 8, right)
                     | (lane_op(v >> 8, 16, amt % 16, right) << 8);
            2'b10: r = lane_op(v & 'hFFFF, 16, amt % 16, right)
                     | (lane_op(v >> 16, 8, amt % 8, right) << 16);
            default: r = lane_op(v & 'hFF, 8, amt % 8, right)
                       | (lane_op((v >> 8) & 'hFF, 8, amt % 8, right) << 8)
                       | (lane_op(v >> 16, 8, amt % 8, right) << 16);
        endcase
        return r[23:0];
    endfunction

    task automatic check(string req, logic [23:0] got, logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: d=%h amt=%0d right=%0b split=%b got=%h exp=%h",
                     req, data, amount, dir_right, split, got, exp);
        end
    endtask

    task automatic apply(logic [23:0] d, int amt, bit right, logic [1:0] g);
        @(posedge clk);
        #1;
        data = d; amount = 5'(amt); dir_right = right; split = g;
        @(negedge clk);
    endtask

    function automatic string tag(logic [1:0] g, int amt);
        if (g == 2'b00 && amt >= 24) return "R8";
        case (g)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        logic [23:0] pats [6];
        pats = '{24'hFFFFFF, 24'h800001, 24'hA5C3_96, 24'h010203, 24'h123456, 24'h000000};
        data = '0; amount = '0; dir_right = 1'b0; split = 2'b00;
        @(negedge clk);
        check("R9 idle", result, 24'h000000);
        for (int p = 0; p < 6; p++)
            for (int g = 0; g < 4; g++)
                for (int r = 0; r < 2; r++)
                    for (int a = 0; a < 32; a++) begin
                        apply(pats[p], a, r[0], 2'(g));
                        check($sformatf("%s/R5", tag(2'(g), a)), result,
                              model(pats[p], a, r[0], 2'(g)));
                    end
        // R7: left shift of lane-top bits must not enter the next lane
        apply(24'h808080, 1, 1'b0, 2'b11);
        check("R7 left seam", result, 24'h000000);
        apply(24'h010101, 1, 1'b1, 2'b11);
        check("R7 right seam", result, 24'h000000);
        apply(24'h0000FF, 4, 1'b0, 2'b01);
        check("R7 seam8", result, 24'h0000F0);
        // R6: zero fill on the vacated side
        apply(24'hFFFFFF, 3, 1'b1, 2'b10);
        check("R6 right fill", result, 24'h1F1FFF);
        // R10: amount 9 acts as 1 in 8-bit lanes
        apply(24'h112233, 9, 1'b0, 2'b11);
        check("R10 mask9", result, 24'h224466);
        // R8: 24-bit lane fully cleared
        apply(24'hFFFFFF, 24, 1'b1, 2'b00);
        check("R8 clear", result, 24'h000000);
        // R9: output changes with inputs alone
        #2 data = 24'h000001; amount = 5'd4; dir_right = 1'b0; split = 2'b00;
        #1 check("R9 async", result, 24'h000010);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: got=timeout exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule